// File: doc/BRIEF.md
# Pipelined Fixed-Point Exponential (Non-Positive Argument)

This unit produces an approximation of e^x for a signed two's-complement fixed-point argument x that is zero or negative. A typical use is the numerator of a numerically stable softmax, where each score has already had the row maximum subtracted. The argument carries a sign bit, `INT_W` integer bits and `FRAC_W` fraction bits. The result is unsigned, with `FRAC_W` fraction bits and two integer bits.

The argument is split into a whole number z of ln2 steps and a small remainder p. A second-order polynomial of the form k1·(p+b1)²+b2 approximates e^p on the remainder interval. That value is then divided by 2^z with a right shift. Three register stages do this work: range reduction, then offset-and-square, then scale, add and shift. The unit accepts a new argument on every clock cycle. A valid flag travels alongside the data with the same delay.

Top module: `fxp_exp_unit`

## Requirements
- R1: While reset is high, and in the first three cycles after it is released, `out_valid` is 0 and `out_y` is 0.
- R2: `out_valid` equals `in_valid` from exactly three clock edges earlier, with back-to-back arguments accepted. Whenever `out_valid` is 0, `out_y` is 0.
- R3: Range reduction uses ln2 rounded to `FRAC_W` fraction bits (L = round(ln2·2^FRAC_W), 177 at the defaults). It computes z = floor(-x / L) and p = x + z·L, so that p lies in (-L, 0]. An argument equal to -k·L therefore gives p = 0 and an output of (1.0 in fixed point) >> k.
- R4: The polynomial value is v = floor(K·(p+B)² / 2^(2·FRAC_W)) + C. K, B and C are 0.3585, 1.353 and 0.344, each rounded to `FRAC_W` fraction bits (92, 346 and 88 at the defaults). For z = 0, `out_y` equals v.
- R5: `out_y` equals v shifted right by z bits, with truncation. The output is unsigned, `FRAC_W`+2 bits wide, with `FRAC_W` fraction bits.
- R6: When z is at least `FRAC_W`+2 (the output width), `out_y` is 0.
- R7: An argument of 0 gives exactly 1.0, which is 256 at the defaults.
- R8: For arguments from -8.0 to 0, |out_y − e^x·2^FRAC_W| ≤ 0.04·e^x·2^FRAC_W + 2 LSB.
- R9: A positive argument (sign bit 0, value nonzero) is treated as 0, so its output equals that for x = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Argument present this cycle |
| in_x | input | 1+INT_W+FRAC_W | Signed fixed-point argument |
| out_valid | output | 1 | Result present this cycle |
| out_y | output | FRAC_W+2 | Unsigned fixed-point approximation of e^x |

## Verification
The bench builds the unit with the default format: a sign bit, 7 integer bits and 8 fraction bits. This 16-bit argument reaches down to -128. The shift count can therefore run far past the 10-bit output width, so the forced-zero region, the most negative code and every exact ln2 multiple from 0 to 14 steps can all be driven directly. The same format allows a sweep of -8.0 to 0 in sixteenth steps against a real-valued exponential, plus valid gaps and random arguments over the full 16-bit range.

// File: rtl/fxp_exp_pkg.sv
package fxp_exp_pkg;

  localparam real LN2_R = 0.6931471805599453;
  localparam real K1_R  = 0.3585;
  localparam real B1_R  = 1.353;
  localparam real B2_R  = 0.344;

  // Round a real constant to the nearest value with frac fraction bits.
  function automatic int quant(input real c, input int frac);
    return $rtoi(c * (2.0 ** frac) + 0.5);
  endfunction

endpackage

// File: rtl/fxp_exp_reduce.sv
module fxp_exp_reduce #(
  parameter int W     = 16,
  parameter int LN2_Q = 177
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_i,
  input  logic signed [W-1:0] x_i,
  output logic                v_o,
  output logic        [W-1:0] z_o,
  output logic        [W-1:0] p_o
);

  localparam logic signed [W-1:0] NEG_LN2 = W'(-LN2_Q);

  logic [W-1:0] mag;
  logic [W-1:0] quo;
  logic [W-1:0] rem;

  // Positive arguments collapse to zero; negative ones become their magnitude.
  always_comb begin
    mag = x_i[W-1] ? W'(-x_i) : '0;
    quo = mag / W'(LN2_Q);
    rem = mag - quo * W'(LN2_Q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      z_o <= '0;
      p_o <= '0;
    end else begin
      v_o <= v_i;
      z_o <= quo;
      p_o <= W'(0) - rem;
    end
  end

  // R3: remainder lands in (-ln2, 0]
  assert_rem_range_R3: assert property (@(posedge clk) disable iff (rst)
    v_i |=> ($signed(p_o) <= 0 && $signed(p_o) > NEG_LN2));

endmodule

// File: rtl/fxp_exp_square.sv
module fxp_exp_square #(
  parameter int W    = 16,
  parameter int B1_Q = 346
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           v_i,
  input  logic [W-1:0]   z_i,
  input  logic [W-1:0]   p_i,
  output logic           v_o,
  output logic [W-1:0]   z_o,
  output logic [2*W-1:0] sq_o
);

  localparam logic [2*W-1:0] SQ_MAX = (2*W)'(B1_Q) * (2*W)'(B1_Q);

  logic [W-1:0] sum;

  always_comb begin
    sum = p_i + W'(B1_Q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o  <= 1'b0;
      z_o  <= '0;
      sq_o <= '0;
    end else begin
      v_o  <= v_i;
      z_o  <= z_i;
      sq_o <= (2*W)'(sum) * (2*W)'(sum);
    end
  end

  // R4: since p is never positive, the square never exceeds b1 squared
  assert_sq_bound_R4: assert property (@(posedge clk) disable iff (rst)
    v_i |=> (sq_o <= SQ_MAX));

endmodule

// File: rtl/fxp_exp_scale.sv
module fxp_exp_scale #(
  parameter int W      = 16,
  parameter int FRAC_W = 8,
  parameter int OW     = 10,
  parameter int K1_Q   = 92,
  parameter int B2_Q   = 88
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           v_i,
  input  logic [W-1:0]   z_i,
  input  logic [2*W-1:0] sq_i,
  output logic           v_o,
  output logic [OW-1:0]  y_o
);

  logic [3*W-1:0] prod;
  logic [W-1:0]   poly;
  logic [OW-1:0]  res;

  always_comb begin
    prod = (3*W)'(K1_Q) * (3*W)'(sq_i);
    poly = W'(prod >> (2*FRAC_W)) + W'(B2_Q);
    res  = (z_i >= W'(OW)) ? '0 : OW'(poly >> z_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      y_o <= '0;
    end else begin
      v_o <= v_i;
      y_o <= v_i ? res : '0;
    end
  end

  // R6: a shift of the full output width or more leaves nothing
  assert_deep_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (v_i && z_i >= W'(OW)) |=> (y_o == '0));

endmodule

// File: rtl/fxp_exp_unit.sv
module fxp_exp_unit #(
  parameter int INT_W  = 7,
  parameter int FRAC_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic signed [INT_W+FRAC_W:0]   in_x,
  output logic                           out_valid,
  output logic        [FRAC_W+1:0]       out_y
);

  import fxp_exp_pkg::*;

  localparam int W     = 1 + INT_W + FRAC_W;
  localparam int OW    = FRAC_W + 2;
  localparam int LN2_Q = quant(LN2_R, FRAC_W);
  localparam int K1_Q  = quant(K1_R, FRAC_W);
  localparam int B1_Q  = quant(B1_R, FRAC_W);
  localparam int B2_Q  = quant(B2_R, FRAC_W);
  localparam logic [OW-1:0] TWO_Q = OW'(1) << (FRAC_W + 1);

  logic           v1, v2;
  logic [W-1:0]   z1, z2, p1;
  logic [2*W-1:0] sq2;

  fxp_exp_reduce #(.W(W), .LN2_Q(LN2_Q)) u_reduce (
    .clk(clk), .rst(rst), .v_i(in_valid), .x_i(in_x),
    .v_o(v1), .z_o(z1), .p_o(p1)
  );

  fxp_exp_square #(.W(W), .B1_Q(B1_Q)) u_square (
    .clk(clk), .rst(rst), .v_i(v1), .z_i(z1), .p_i(p1),
    .v_o(v2), .z_o(z2), .sq_o(sq2)
  );

  fxp_exp_scale #(.W(W), .FRAC_W(FRAC_W), .OW(OW), .K1_Q(K1_Q), .B2_Q(B2_Q)) u_scale (
    .clk(clk), .rst(rst), .v_i(v2), .z_i(z2), .sq_i(sq2),
    .v_o(out_valid), .y_o(out_y)
  );

  // Cycles since reset, saturating at the pipeline depth.
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R2: valid emerges exactly three edges after it enters
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R5: result stays below 2.0
  assert_out_bound_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_y < TWO_Q));

endmodule

// File: tb/fxp_exp_unit_test.sv
`timescale 1ns/1ps
module fxp_exp_unit_test;

  localparam int INT_W  = 7;
  localparam int FRAC_W = 8;
  localparam int W      = 1 + INT_W + FRAC_W;
  localparam int OW     = FRAC_W + 2;
  localparam int LN2    = $rtoi(0.6931471805599453 * (2.0 ** FRAC_W) + 0.5);
  localparam int KK     = $rtoi(0.3585 * (2.0 ** FRAC_W) + 0.5);
  localparam int BB     = $rtoi(1.353 * (2.0 ** FRAC_W) + 0.5);
  localparam int CC     = $rtoi(0.344 * (2.0 ** FRAC_W) + 0.5);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] in_x = '0;
  logic                out_valid;
  logic [OW-1:0]       out_y;

  int nchecks = 0;
  int nfail   = 0;
  bit done    = 1'b0;

  bit    qv[$];
  int    qx[$];
  int    seed = 32'h1357_9bdf;

  always #2 clk = ~clk;

  fxp_exp_unit #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_y(out_y)
  );

  function automatic int model(input int x);
    longint mag, z, r, s, v;
    mag = (x < 0) ? -x : 0;
    z   = mag / LN2;
    r   = mag - z * LN2;
    s   = BB - r;
    v   = ((KK * s * s) >> (2 * FRAC_W)) + CC;
    if (z >= OW) return 0;
    return int'(v >> z);
  endfunction

  function automatic string tag_of(input bit v, input int x);
    int mag;
    if (!v) return "R2";
    if (x > 0) return "R9";
    if (x == 0) return "R7";
    mag = -x;
    if (mag / LN2 >= OW) return "R6";
    if (mag % LN2 == 0) return "R3";
    if (mag < LN2) return "R4";
    return "R5";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input bit v, input int x);
    bit ev;
    int ex, ey;
    real ideal, err;
    @(negedge clk);
    if (qv.size() == 3) begin
      ev = qv.pop_front();
      ex = qx.pop_front();
      ey = ev ? model(ex) : 0;
      chk(out_valid == ev && int'(out_y) == ey, tag_of(ev, ex),
          int'(out_valid) * 100000 + int'(out_y), int'(ev) * 100000 + ey);
      if (ev && ex <= 0 && ex >= -8 * (1 << FRAC_W)) begin
        ideal = $exp(real'(ex) / (2.0 ** FRAC_W)) * (2.0 ** FRAC_W);
        err   = real'(out_y) - ideal;
        if (err < 0.0) err = -err;
        chk(err <= 0.04 * ideal + 2.0, "R8", int'(out_y), $rtoi(ideal + 0.5));
      end
    end else begin
      // first cycles after reset release
      chk(out_valid == 1'b0 && out_y == '0, "R1",
          int'(out_valid) * 100000 + int'(out_y), 0);
    end
    in_valid = v;
    in_x     = x[W-1:0];
    qv.push_back(v);
    qx.push_back(x);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nfail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    // R1: reset state while reset is held
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && out_y == '0, "R1",
        int'(out_valid) * 100000 + int'(out_y), 0);
    rst = 1'b0;

    step(1'b1, 0);
    step(1'b1, 5);
    step(1'b1, 32767);
    step(1'b1, -1);
    for (int k = 0; k <= 14; k++) step(1'b1, -k * LN2);
    step(1'b1, -OW * LN2 + 1);
    step(1'b1, -32768);
    for (int i = 0; i <= 128; i++) step(1'b1, -16 * i);
    for (int i = 0; i < 40; i++) step((i % 3) != 0, -37 * i);
    for (int i = 0; i < 300; i++) begin
      seed = seed * 1103515245 + 12345;
      step(seed[30], int'($signed(seed[23:8])));
    end
    for (int i = 0; i < 4; i++) step(1'b0, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

endmodule